// File: doc/BRIEF.md
# Sync-Header Pilot Multiblock Aligner

This receive-side block recovers multiblock framing from the stream of sync-header bits, one bit per 64-bit block, after block alignment has already been achieved. In the error-correcting framing mode, a multiblock of 32 blocks ends with a five-bit marker: four zeros followed by a one. The rest of the header bits carry parity and one flag bit, so the marker can also turn up by chance at other positions. A single sighting is therefore never trusted. The aligner waits until the marker repeats at exactly the same phase over several consecutive multiblocks.

Once aligned, the block pulses a start strobe on the first block of every multiblock. It also presents the end-of-extended-multiblock flag, which is read from a fixed header position of the most recent multiblock. Alignment survives a few corrupted markers. A longer run of misses drops lock and restarts the hunt. Cycles where the block-valid strobe is low carry no header bit and are skipped entirely.

Top module: `mb_pilot_aligner`

## Requirements
- R1: After reset, `locked`, `mb_start` and `emb_end` are all 0.
- R2: A marker hit occurs on a valid block when the last five valid header bits, oldest first and ending with the current one, read 0,0,0,0,1. Bits from before reset never form a hit.
- R3: Starting from the hunt, `locked` rises in the cycle after the third consecutive marker hit. Each of these hits must be exactly 32 valid blocks after the one before it. `locked` stays 0 after only two such hits.
- R4: While alignment is being confirmed, a missing marker at the expected block (index 31) returns the block to the hunt, and the hit count starts again.
- R5: Cycles with `blk_valid` low change no state: they shift no header bit, advance no position and alter no output register.
- R6: While locked, `mb_start` is high for exactly the valid block that follows each expected marker end (block index 0 of the multiblock), and low otherwise.
- R7: While locked, `emb_end` equals the header bit at block index 26 of the most recently received multiblock. It is 0 whenever `locked` is 0.
- R8: While locked, one to three consecutive misses at index 31 keep lock, and a hit at index 31 clears the miss count.
- R9: The fourth consecutive miss at index 31 clears `locked` in the following cycle, and the hunt restarts.
- R10: While locked or confirming, a marker hit at any index other than 31 has no effect on the multiblock phase or on lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | High when `hdr_bit` carries the header bit of a block |
| hdr_bit | input | 1 | Sync-header data bit of the current block |
| mb_start | output | 1 | Strobe on the first block of each aligned multiblock |
| emb_end | output | 1 | End-of-extended-multiblock flag of the latest multiblock |
| locked | output | 1 | Multiblock alignment acquired |

## Verification
Clean multiblocks with all-ones parity show the exact lock cycle, after the third marker hit and not after the second. Parity fields seeded with a false marker show that a chance pattern away from index 31 leaves the phase unchanged. Controlled runs of three and four corrupted markers separate a tolerated fade from a loss of lock, and a single corruption during confirmation shows the hunt restarting. Long random stretches then mix zero-heavy parity, random flag bits, occasional corrupted markers, invalid cycles carrying junk, and forced phase slips that demand realignment. Every output is compared with a reference model on every cycle.

// File: rtl/mb_pilot_aligner.sv
module mb_pilot_aligner #(
  parameter int MB_LEN      = 32,
  parameter int PILOT_W     = 5,
  parameter int EMB_POS     = 26,
  parameter int LOCK_HITS   = 3,
  parameter int LOSS_MISSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_valid,
  input  logic hdr_bit,
  output logic mb_start,
  output logic emb_end,
  output logic locked
);

  localparam int PW = $clog2(MB_LEN);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(LOSS_MISSES + 1);
  localparam logic [PW-1:0]      POS_LAST = PW'(MB_LEN - 1);
  localparam logic [PW-1:0]      POS_EMB  = PW'(EMB_POS);
  localparam logic [PILOT_W-1:0] PILOT    = PILOT_W'(1);
  localparam logic [HW-1:0]      HITS_FIN = HW'(LOCK_HITS - 1);
  localparam logic [MW-1:0]      MISS_FIN = MW'(LOSS_MISSES - 1);

  typedef enum logic [1:0] {HUNT, CONFIRM, TRACK} st_t;

  st_t               st_q;
  logic [PILOT_W-1:0] win_q;
  logic [PW-1:0]      pos_q;
  logic [HW-1:0]      hits_q;
  logic [MW-1:0]      miss_q;
  logic               emb_q;

  wire [PILOT_W-1:0] win_d = {win_q[PILOT_W-2:0], hdr_bit};
  wire hit     = blk_valid && (win_d == PILOT);
  wire at_end  = blk_valid && (st_q != HUNT) && (pos_q == POS_LAST);
  wire [PW-1:0] pos_inc = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

  assign locked   = (st_q == TRACK);
  assign mb_start = locked && blk_valid && (pos_q == '0);
  assign emb_end  = locked && emb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= HUNT;
      win_q  <= '1;
      pos_q  <= '0;
      hits_q <= '0;
      miss_q <= '0;
      emb_q  <= 1'b0;
    end else if (blk_valid) begin
      win_q <= win_d;
      if (st_q != HUNT && pos_q == POS_EMB)
        emb_q <= hdr_bit;
      case (st_q)
        HUNT: begin
          if (hit) begin
            st_q   <= CONFIRM;
            hits_q <= HW'(1);
            pos_q  <= '0;
          end
        end
        CONFIRM: begin
          pos_q <= pos_inc;
          if (at_end) begin
            if (!hit) begin
              st_q <= HUNT;
            end else if (hits_q == HITS_FIN) begin
              st_q   <= TRACK;
              miss_q <= '0;
            end else begin
              hits_q <= hits_q + 1'b1;
            end
          end
        end
        TRACK: begin
          pos_q <= pos_inc;
          if (at_end) begin
            if (hit)
              miss_q <= '0;
            else if (miss_q == MISS_FIN)
              st_q <= HUNT;
            else
              miss_q <= miss_q + 1'b1;
          end
        end
        default: st_q <= HUNT;
      endcase
    end
  end

  p_start_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_start |-> locked);

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mb_start |=> !mb_start);

  p_emb_quiet_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !emb_end);

  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> ($stable(locked) && $stable(emb_end)));

  p_lock_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit));

  p_drop_after_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(blk_valid && !hit));

endmodule

// File: tb/mb_pilot_aligner_tb_top.sv
module mb_pilot_aligner_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_valid = 1'b0;
  logic hdr_bit = 1'b0;
  logic mb_start, emb_end, locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_st, m_pos, m_hits, m_miss;
  bit m_emb;
  bit [4:0] m_sh;

  always #2 clk = ~clk;

  mb_pilot_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .hdr_bit(hdr_bit),
    .mb_start(mb_start), .emb_end(emb_end), .locked(locked)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_emb = 1'b0; m_sh = 5'b11111;
  endtask

  task automatic model_step(input bit b);
    bit [4:0] w;
    bit h;
    w = {m_sh[3:0], b};
    h = (w == 5'b00001);
    if (m_st != 0 && m_pos == 26) m_emb = b;
    case (m_st)
      0: if (h) begin m_st = 1; m_hits = 1; m_pos = 0; end
      1: begin
        if (m_pos == 31) begin
          if (!h) m_st = 0;
          else if (m_hits == 2) begin m_st = 2; m_miss = 0; end
          else m_hits++;
        end
        m_pos = (m_pos + 1) % 32;
      end
      default: begin
        if (m_pos == 31) begin
          if (h) m_miss = 0;
          else if (m_miss == 3) m_st = 0;
          else m_miss++;
        end
        m_pos = (m_pos + 1) % 32;
      end
    endcase
    m_sh = w;
  endtask

  task automatic blk(input bit v, input bit b);
    @(negedge clk);
    blk_valid = v;
    hdr_bit = b;
    #1;
    chk(locked, m_st == 2, "R3 R4 R9 locked");
    chk(mb_start, (m_st == 2) && v && (m_pos == 0), "R6 R10 mb_start");
    chk(emb_end, (m_st == 2) && m_emb, "R7 emb_end");
    if (v) model_step(b);
  endtask

  task automatic send_mb(input logic [25:0] par, input bit emb, input int pil, input int gap_pct);
    for (int i = 0; i < 32; i++) begin
      bit b;
      if (i < 26) b = par[i];
      else if (i == 26) b = emb;
      else if (i < 30) b = 1'b0;
      else if (i == 30) b = (pil == 2);
      else b = (pil != 1);
      while (gap_pct > 0 && $urandom_range(99) < gap_pct)
        blk(1'b0, 1'($urandom_range(1)));
      blk(1'b1, b);
    end
  endtask

  task automatic expect_state(input bit exp_lock, input bit exp_emb, input string tag);
    @(negedge clk);
    blk_valid = 1'b0;
    hdr_bit = 1'b1;
    #1;
    chk(locked, exp_lock, {tag, " locked"});
    chk(emb_end, exp_emb, {tag, " emb_end"});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic [25:0] fake;
    seed_dummy = $urandom(20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(locked, 1'b0, "R1 locked");
    chk(mb_start, 1'b0, "R1 mb_start");
    chk(emb_end, 1'b0, "R1 emb_end");
    rst_n = 1'b1;

    // R2/R3: clean multiblocks; lock only after the third marker hit
    send_mb('1, 1'b0, 0, 0);
    send_mb('1, 1'b0, 0, 0);
    expect_state(1'b0, 1'b0, "R3 two hits");
    send_mb('1, 1'b0, 0, 0);
    expect_state(1'b1, 1'b0, "R2 R3 three hits");

    // R7: flag bit at index 26
    send_mb('1, 1'b1, 0, 0);
    expect_state(1'b1, 1'b1, "R7 flag set");
    send_mb('1, 1'b0, 0, 0);
    expect_state(1'b1, 1'b0, "R7 flag clear");

    // R10: false marker ending at index 9
    fake = '1;
    fake[8:5] = 4'b0000;
    send_mb(fake, 1'b0, 0, 0);
    send_mb(fake, 1'b0, 0, 0);
    expect_state(1'b1, 1'b0, "R10 false marker");

    // R5: invalid gaps with junk data while locked
    send_mb('1, 1'b1, 0, 50);
    expect_state(1'b1, 1'b1, "R5 gaps");

    // R8: three misses tolerated, hit clears the count
    repeat (3) send_mb('1, 1'b1, 2, 0);
    expect_state(1'b1, 1'b1, "R8 three misses");
    send_mb('1, 1'b0, 0, 0);
    repeat (3) send_mb('1, 1'b1, 2, 0);
    expect_state(1'b1, 1'b1, "R8 count cleared");

    // R9: fourth miss drops lock
    send_mb('1, 1'b1, 2, 0);
    expect_state(1'b0, 1'b0, "R9 fourth miss");

    // R4: a miss during confirmation restarts the count
    send_mb('1, 1'b0, 0, 0);
    send_mb('1, 1'b1, 2, 0);
    send_mb('1, 1'b0, 0, 0);
    send_mb('1, 1'b0, 0, 0);
    expect_state(1'b0, 1'b0, "R4 restarted");
    send_mb('1, 1'b0, 0, 0);
    expect_state(1'b1, 1'b0, "R4 relock");

    // Random phase compared with the reference model every cycle
    for (int n = 0; n < 300; n++) begin
      logic [25:0] par;
      int pil;
      par = 26'($urandom & $urandom);
      pil = ($urandom_range(9) == 0) ? 1 : 0;
      if (n % 50 == 49) begin
        int slip;
        slip = $urandom_range(31, 1);
        for (int k = 0; k < slip; k++) blk(1'b1, 1'b1);
      end
      send_mb(par, 1'($urandom_range(1)), pil, 20);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule